// File: doc/BRIEF.md
# Iterative Shift-Add Unsigned Multiplier

This block forms the unsigned product of two operands one bit per clock. A single start pulse captures both operands: the multiplicand goes into a register that never moves, and the multiplier goes into the low half of a double-width product register whose upper half is cleared.

On every working cycle the block tests the product register's least significant bit. When that bit is 1, it adds the multiplicand into the upper half; when it is 0, it adds nothing. It then shifts the whole register right by one, with the adder carry entering the top bit. Bits that have moved below the midpoint are never added into again, so the adder spans only the upper half plus one carry bit.

After one step per multiplier bit, the block drops its busy flag and raises a one-cycle done pulse. The full product stays on the output until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While rst_ni is low and after its release, busy_o and done_o are 0 and product_o is all zeros.
- R2: A start_i sampled high while busy_o is low is accepted: busy_o reads 1 in the following cycle.
- R3: After done_o, product_o equals the unsigned 2*OP_W-bit product of the multiplicand and multiplier captured at the accepted start.
- R4: The adder carry-out is kept: an all-ones by all-ones multiply (default width) yields 0xFFFFFFFE00000001.
- R5: Exactly OP_W add/shift steps run: done_o is high in the cycle that begins with the OP_W-th rising edge after the accepting edge (33 bench cycles from driving start_i for OP_W = 32).
- R6: done_o is high for exactly one cycle, and busy_o is 0 whenever done_o is 1.
- R7: start_i sampled high while busy_o is high is ignored: the running operation finishes on schedule with its original operands.
- R8: product_o holds its value after done_o until the next accepted start.
- R9: A step whose tested low bit is 0 adds nothing and only shifts right; 0b1101 by 0b1100 yields 0b10011100, and any operand of zero yields zero.
- R10: The multiplier is held only in the low half of the product register, with the upper half cleared at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the rising edge |
| multiplicand_i | input | OP_W | Multiplicand operand |
| multiplier_i | input | OP_W | Multiplier operand |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*OP_W | Product register contents |

## Verification
The bench applies several directed operand pairs, each chosen to expose one kind of fault:
- the small worked example and multiplications by one expose shift-only steps that wrongly add;
- zero operands expose a failure to clear the upper half at load;
- all-ones operands expose a dropped carry bit.

Seeded random operand pairs then cover general carry and bit-position faults. The bench counts cycles to done on every vector, so a miscounted step total is caught. It also pulses start mid-run with other operands, which exposes a design that restarts when it should not.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned MUL_OP_W_DEF = 32;

  function automatic int unsigned cnt_width(input int unsigned steps);
    return (steps > 1) ? $clog2(steps) : 1;
  endfunction
endpackage

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned OP_W = MUL_OP_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = cnt_width(OP_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OP_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic             last_step;

  assign load_o    = start_i & ~busy_q;
  assign step_o    = busy_q;
  assign last_step = busy_q & (cnt_q == LAST_CNT);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last_step) busy_q <= 1'b0;
        else           cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST_CNT));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int unsigned OP_W = MUL_OP_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned SUM_W  = OP_W + 1;

  logic [OP_W-1:0]   mcand_q;
  logic [PROD_W-1:0] prod_q;
  logic [SUM_W-1:0]  addend;
  logic [SUM_W-1:0]  upper_sum;
  logic [PROD_W-1:0] prod_next;

  // adder spans only the upper half; carry kept as the extra bit
  assign addend    = prod_q[0] ? {1'b0, mcand_q} : '0;
  assign upper_sum = {1'b0, prod_q[PROD_W-1:OP_W]} + addend;
  assign prod_next = {upper_sum, prod_q[OP_W-1:1]};
  assign prod_o    = prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{OP_W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= prod_next;
    end
  end

  // R10
  load_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (prod_q[OP_W-1:0] == $past(mplier_i) && prod_q[PROD_W-1:OP_W] == '0));

  // R9
  zero_bit_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !prod_q[0]) |=> (prod_q == ($past(prod_q) >> 1)));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(prod_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import mul_pkg::*;
#(
  parameter int unsigned OP_W = MUL_OP_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   multiplicand_i,
  input  logic [OP_W-1:0]   multiplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*OP_W-1:0] product_o
);
  logic load;
  logic step;

  mul_step_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_datapath #(.OP_W(OP_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (multiplicand_i),
    .mplier_i(multiplier_i),
    .prod_o  (product_o)
  );

  // R6
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
  localparam int unsigned OP_W   = 32;
  localparam time         CLK_PERIOD = 10ns;
  localparam int          EXP_CYCLES = OP_W + 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [OP_W-1:0]   multiplicand_i = '0;
  logic [OP_W-1:0]   multiplier_i = '0;
  logic              busy_o;
  logic              done_o;
  logic [2*OP_W-1:0] product_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  shift_add_mul #(.OP_W(OP_W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [2*OP_W-1:0] ref_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    return {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
  endfunction

  task automatic check(input string req, input logic [2*OP_W-1:0] act, input logic [2*OP_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input bit poke);
    int cycles;
    logic [2*OP_W-1:0] held;
    @(negedge clk_i);
    multiplicand_i = a;
    multiplier_i   = b;
    start_i        = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cycles  = 1;
    // R2
    check("R2 busy after start", 64'(busy_o), 64'd1);
    while (!done_o && cycles < 3 * EXP_CYCLES) begin
      if (poke && cycles == 5) begin
        multiplicand_i = ~a;
        multiplier_i   = b ^ 32'h5A5A_A5A5;
        start_i        = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cycles++;
    end
    start_i = 1'b0;
    // R5 (R7 when poked: ignored start must not lengthen the run)
    check(poke ? "R7 R5 step count" : "R5 step count", 64'(cycles), 64'(EXP_CYCLES));
    // R3 / R7
    check(poke ? "R7 product kept" : "R3 product", product_o, ref_mul(a, b));
    // R6
    check("R6 busy low at done", 64'(busy_o), 64'd0);
    held = product_o;
    @(negedge clk_i);
    check("R6 done single cycle", 64'(done_o), 64'd0);
    repeat (2) @(negedge clk_i);
    // R8
    check("R8 product held", product_o, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    // R1
    check("R1 reset busy", 64'(busy_o), 64'd0);
    check("R1 reset done", 64'(done_o), 64'd0);
    check("R1 reset product", product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", {62'd0, busy_o, done_o}, 64'd0);

    // R9 worked example and zero operands
    run_mul(32'b1101, 32'b1100, 1'b0);
    check("R9 example", product_o, 64'b10011100);
    run_mul(32'h0, 32'hFFFF_FFFF, 1'b0);
    check("R9 zero multiplicand", product_o, 64'd0);
    // R10 zero multiplier after nonzero run: upper half must be cleared at load
    run_mul(32'hDEAD_BEEF, 32'h0, 1'b0);
    check("R10 zero multiplier", product_o, 64'd0);
    run_mul(32'h1234_5678, 32'h1, 1'b0);
    run_mul(32'h1, 32'h8000_0000, 1'b0);
    // R4
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check("R4 carry kept", product_o, 64'hFFFF_FFFE_0000_0001);
    // R7
    run_mul(32'h0BAD_F00D, 32'h7654_3210, 1'b1);

    for (int i = 0; i < 40; i++) begin
      run_mul($urandom, $urandom, (i % 8) == 3);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule